// File: doc/BRIEF.md
# Programmable Output Timing Pair Generator

The block drives several independent timing pairs. Each pair is a bit clock and a frame pulse. All of them are derived from one master clock that runs at twice the fastest output rate. A single frame counter spans a 125 us frame of 16384 master cycles. Every pair reads that counter and derives its clock from one bit of it. The pair shapes its frame pulse around the frame boundary, using either a centred pulse or a leading pulse.

A write strobe loads one control word that configures every pair at once. The control word holds a 7-bit field for each pair: reference source, rate, pulse format, pulse polarity and clock polarity. A pair may name an external input clock as its reference. In that case the requested rate must not exceed the rate that input clock is declared to run at. An illegal request sets the pair's error flag, and the pair keeps its previous legal setting.

Top module: `tpair_gen`

## Requirements
- R1: After reset, pair k runs at rate code 3-k (pair 0 at 65.536 MHz down to pair 3 at 8.192 MHz). Every pair starts with the centred pulse format, an active-low frame pulse, clock polarity 0 and the internal source. Before the first clock edge the outputs read ck_o=0, fp_o all ones and cfg_err_o=0.
- R2: Rate code r (0=8.192, 1=16.384, 2=32.768, 3=65.536 MHz) gives a clock period of 2^(4-r) master cycles at 50% duty. With clock polarity 0, the low half comes first after the frame boundary. Each pair runs independently of the others.
- R3: Clock polarity bit (field bit 6) set to 1 inverts the bit clock.
- R4: The frame is 16384 master cycles long. A pulse of 2^(4-r) master cycles occurs exactly once per frame.
- R5: With format bit (field bit 4) at 0, the pulse is one output period wide and centred on the frame boundary. It covers the last half period of a frame and the first half period of the next.
- R6: With format bit 1, the pulse is one output period wide and starts at the frame boundary.
- R7: Pulse polarity bit (field bit 5) at 0 gives an active-low pulse; at 1 it gives an active-high pulse.
- R8: Pair k's field sits at cfg_word_i bits 7k+6..7k, with source at bits 7k+1..7k and rate at bits 7k+3..7k+2. Source 0 selects the internal clock, which allows any rate. Source n (1..3) selects input clock n, whose rate code is ref_rate_i[2n-1:2n-2]. A legal write is stored and clears the pair's error flag.
- R9: A write whose rate exceeds the selected input clock's rate sets the pair's error flag and leaves its setting unchanged. The flag changes only on writes.
- R10: Outputs are registered. The levels after clock edge n reflect frame count n-1 (counting from 0 at the first edge after reset). A write sampled at edge w takes effect in the outputs after edge w+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, twice the top output rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load cfg_word_i into all pairs |
| cfg_word_i | input | 28 | Packed 7-bit fields, one per pair |
| ref_rate_i | input | 6 | Rate code of each of the three input clocks |
| ck_o | output | 4 | Bit clock of each pair |
| fp_o | output | 4 | Frame pulse of each pair |
| cfg_err_o | output | 4 | Illegal-rate flag of each pair |

## Verification
Each output reflects the frame count and setting from one edge earlier. A new word therefore shows up in the error flags one edge after the strobe and in the clock and pulse levels two edges after it. The bench model applies a write at the edge where the strobe is sampled. It derives the expected levels from the count and setting held before that edge, and compares at the following falling edge. The error flag is also checked explicitly at the first falling edge after an illegal write. The pulse width per frame is checked by counting active cycles over one full frame.

// File: rtl/tpair_pkg.sv
package tpair_pkg;
  localparam int unsigned RATE_W  = 2;
  localparam int unsigned SRC_W   = 2;
  localparam int unsigned N_RATES = 1 << RATE_W;
  localparam int unsigned CFG_W   = SRC_W + RATE_W + 3;

  typedef struct packed {
    logic              ck_pol;
    logic              fp_pol;
    logic              gci;
    logic [RATE_W-1:0] rate;
    logic [SRC_W-1:0]  src;
  } pair_cfg_t;

  function automatic pair_cfg_t dflt_cfg(int unsigned idx);
    pair_cfg_t c;
    c = '0;
    c.rate = (idx < N_RATES) ? RATE_W'(N_RATES - 1 - idx) : '0;
    return c;
  endfunction
endpackage

// File: rtl/tpair_frame_cnt.sv
module tpair_frame_cnt #(
  parameter int unsigned FRAME_LEN = 16384,
  parameter int unsigned CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_o <= '0;
    else if (cnt_o == LAST) cnt_o <= '0;
    else                    cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/tpair_cfg_reg.sv
module tpair_cfg_reg
  import tpair_pkg::*;
#(
  parameter int unsigned N_REF    = 3,
  parameter int unsigned PAIR_IDX = 0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  pair_cfg_t               wr_cfg_i,
  input  logic [N_REF*RATE_W-1:0] ref_rate_i,
  output pair_cfg_t               cfg_o,
  output logic                    err_o
);
  logic legal;

  always_comb begin
    legal = (wr_cfg_i.src == '0);
    for (int i = 0; i < N_REF; i++) begin
      if (int'(wr_cfg_i.src) == i + 1)
        legal = (wr_cfg_i.rate <= ref_rate_i[RATE_W*i +: RATE_W]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= dflt_cfg(PAIR_IDX);
      err_o <= 1'b0;
    end else if (we_i) begin
      if (legal) cfg_o <= wr_cfg_i;
      err_o <= ~legal;
    end
  end
endmodule

// File: rtl/tpair_shaper.sv
module tpair_shaper
  import tpair_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 16384,
  parameter int unsigned CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  pair_cfg_t        cfg_i,
  output logic             ck_o,
  output logic             fp_o
);
  localparam int unsigned XW = CNT_W + 1;

  logic [RATE_W-1:0] sh;
  logic [XW-1:0]     half, cnt_x;
  logic              act;

  always_comb begin
    sh    = RATE_W'(N_RATES - 1) - cfg_i.rate;
    half  = XW'(1) << sh;
    cnt_x = {1'b0, cnt_i};
    if (cfg_i.gci) act = cnt_x < (half << 1);
    else           act = (cnt_x >= XW'(FRAME_LEN) - half) || (cnt_x < half);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_o <= 1'b0;
      fp_o <= 1'b1;
    end else begin
      ck_o <= cnt_i[sh] ^ cfg_i.ck_pol;
      fp_o <= act ~^ cfg_i.fp_pol;
    end
  end
endmodule

// File: rtl/tpair_gen.sv
module tpair_gen
  import tpair_pkg::*;
#(
  parameter int unsigned N_PAIRS   = 4,
  parameter int unsigned N_REF     = 3,
  parameter int unsigned FRAME_LEN = 16384
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cfg_we_i,
  input  logic [N_PAIRS*CFG_W-1:0]  cfg_word_i,
  input  logic [N_REF*RATE_W-1:0]   ref_rate_i,
  output logic [N_PAIRS-1:0]        ck_o,
  output logic [N_PAIRS-1:0]        fp_o,
  output logic [N_PAIRS-1:0]        cfg_err_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_LEN);

  logic [CNT_W-1:0]         cnt_q;
  logic [N_PAIRS*CFG_W-1:0] cfg_flat;

  tpair_frame_cnt #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) i_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_o(cnt_q)
  );

  for (genvar g = 0; g < N_PAIRS; g++) begin : g_pair
    pair_cfg_t cfg_q;

    tpair_cfg_reg #(.N_REF(N_REF), .PAIR_IDX(g)) i_cfg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (cfg_we_i),
      .wr_cfg_i  (pair_cfg_t'(cfg_word_i[g*CFG_W +: CFG_W])),
      .ref_rate_i(ref_rate_i),
      .cfg_o     (cfg_q),
      .err_o     (cfg_err_o[g])
    );

    tpair_shaper #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) i_shp (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cnt_i (cnt_q),
      .cfg_i (cfg_q),
      .ck_o  (ck_o[g]),
      .fp_o  (fp_o[g])
    );

    assign cfg_flat[g*CFG_W +: CFG_W] = cfg_q;
  end
endmodule

// File: rtl/tpair_gen_chk.sv
module tpair_gen_chk
  import tpair_pkg::*;
#(
  parameter int unsigned N_PAIRS   = 4,
  parameter int unsigned FRAME_LEN = 16384,
  parameter int unsigned CNT_W     = $clog2(FRAME_LEN)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     cfg_we_i,
  input logic [N_PAIRS*CFG_W-1:0] cfg_word_i,
  input logic [N_PAIRS-1:0]       ck_o,
  input logic [N_PAIRS-1:0]       cfg_err_o,
  input logic [CNT_W-1:0]         cnt_q,
  input logic [N_PAIRS*CFG_W-1:0] cfg_flat
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              age_q <= '0;
    else if (age_q != 2'd3)   age_q <= age_q + 1'b1;
  end

  assert_cnt_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == CNT_W'(FRAME_LEN - 1) |=> cnt_q == '0);

  assert_cnt_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != CNT_W'(FRAME_LEN - 1) |=> cnt_q == $past(cnt_q) + 1'b1);

  for (genvar g = 0; g < N_PAIRS; g++) begin : g_chk
    assert_err_only_on_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(cfg_we_i) |-> $stable(cfg_err_o[g]));

    assert_hold_on_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(cfg_we_i) && cfg_err_o[g] |-> $stable(cfg_flat[g*CFG_W +: CFG_W]));

    assert_store_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(cfg_we_i) && !cfg_err_o[g]
        |-> cfg_flat[g*CFG_W +: CFG_W] == $past(cfg_word_i[g*CFG_W +: CFG_W]));

    // R10: output at an edge uses the setting held before that edge
    assert_fast_toggle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      age_q >= 2'd2 && $past(cfg_flat[g*CFG_W +: CFG_W]) == $past(cfg_flat[g*CFG_W +: CFG_W], 2)
        && $past(cfg_flat[g*CFG_W+2 +: 2]) == 2'd3 |-> ck_o[g] != $past(ck_o[g]));
  end
endmodule

bind tpair_gen tpair_gen_chk #(.N_PAIRS(N_PAIRS), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) i_tpair_gen_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_word_i(cfg_word_i),
  .ck_o(ck_o), .cfg_err_o(cfg_err_o), .cnt_q(cnt_q), .cfg_flat(cfg_flat)
);

// File: tb/test_tpair_gen.sv
module test_tpair_gen;
  localparam int F = 16384;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [27:0] cfg_word_i = '0;
  logic [5:0]  ref_rate_i = '0;
  logic [3:0]  ck_o, fp_o, cfg_err_o;

  tpair_gen i_tpair_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_word_i(cfg_word_i),
    .ref_rate_i(ref_rate_i), .ck_o(ck_o), .fp_o(fp_o), .cfg_err_o(cfg_err_o)
  );

  always #2.5 clk_i = ~clk_i;

  int    n_chk = 0, n_fail = 0;
  bit    live = 0;
  string cur_req = "R1/R5/R10";

  int m_cnt;
  int m_src[4], m_rate[4], m_gci[4], m_fpp[4], m_ckp[4];
  bit e_ck[4], e_fp[4], e_err[4];

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [6:0] fld(int src, int rate, int gci, int fpp, int ckp);
    return {1'(ckp), 1'(fpp), 1'(gci), 2'(rate), 2'(src)};
  endfunction

  task automatic model_reset();
    m_cnt = 0;
    for (int k = 0; k < 4; k++) begin
      m_src[k] = 0; m_rate[k] = 3 - k; m_gci[k] = 0; m_fpp[k] = 0; m_ckp[k] = 0;
      e_ck[k] = 0; e_fp[k] = 1; e_err[k] = 0;
    end
  endtask

  initial model_reset();

  // behavioural reference, one step per rising edge
  always @(posedge clk_i) begin
    if (rst_ni) begin
      for (int k = 0; k < 4; k++) begin
        int  h;
        bit  act;
        h = 1 << (3 - m_rate[k]);
        e_ck[k] = (((m_cnt / h) % 2) != 0) ^ (m_ckp[k] != 0);
        act = m_gci[k] ? (m_cnt < 2 * h) : (m_cnt >= F - h || m_cnt < h);
        e_fp[k] = m_fpp[k] ? act : !act;
      end
      if (cfg_we_i) begin
        for (int k = 0; k < 4; k++) begin
          logic [6:0] w;
          int s, r, lim;
          bit ok;
          w = cfg_word_i[7*k +: 7];
          s = int'(w[1:0]); r = int'(w[3:2]);
          lim = (s == 0) ? 3 : int'(ref_rate_i[2*(s-1) +: 2]);
          ok = r <= lim;
          e_err[k] = !ok;
          if (ok) begin
            m_src[k] = s; m_rate[k] = r; m_gci[k] = w[4]; m_fpp[k] = w[5]; m_ckp[k] = w[6];
          end
        end
      end
      m_cnt = (m_cnt + 1) % F;
    end
  end

  always @(negedge clk_i) begin
    if (live) begin
      for (int k = 0; k < 4; k++) begin
        chk(ck_o[k] == e_ck[k], {cur_req, " ck"}, ck_o[k], e_ck[k]);
        chk(fp_o[k] == e_fp[k], {cur_req, " fp"}, fp_o[k], e_fp[k]);
        chk(cfg_err_o[k] == e_err[k], "R9 err", cfg_err_o[k], e_err[k]);
      end
    end
  end

  task automatic wr(logic [27:0] w);
    cfg_word_i = w;
    cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int act0, act3;
    repeat (3) @(negedge clk_i);
    chk(ck_o == 4'h0, "R1 reset ck", ck_o, 0);
    chk(fp_o == 4'hF, "R1 reset fp", fp_o, 15);
    chk(cfg_err_o == 4'h0, "R1 reset err", cfg_err_o, 0);
    rst_ni = 1'b1;
    live = 1;

    // R4: active cycles over one whole frame
    act0 = 0; act3 = 0;
    repeat (F) begin
      @(negedge clk_i);
      if (!fp_o[0]) act0++;
      if (!fp_o[3]) act3++;
    end
    chk(act0 == 2, "R4 pair0 pulse width", act0, 2);
    chk(act3 == 16, "R4 pair3 pulse width", act3, 16);
    repeat (100) @(negedge clk_i);

    cur_req = "R2";
    wr({fld(0,2,0,0,0), fld(0,3,0,0,0), fld(0,1,0,0,0), fld(0,0,0,0,0)});
    repeat (17000) @(negedge clk_i);

    cur_req = "R3/R7";
    wr({fld(0,0,0,1,1), fld(0,3,0,1,0), fld(0,1,0,0,1), fld(0,2,0,1,1)});
    repeat (17000) @(negedge clk_i);

    cur_req = "R6";
    wr({fld(0,0,1,0,0), fld(0,1,1,1,0), fld(0,3,1,0,1), fld(0,2,1,1,1)});
    repeat (17000) @(negedge clk_i);

    cur_req = "R8";
    ref_rate_i = {2'd3, 2'd1, 2'd0};
    wr({fld(3,2,0,1,0), fld(2,1,1,0,0), fld(1,0,0,0,1), fld(0,3,0,0,0)});
    chk(cfg_err_o == 4'h0, "R8 legal sources", cfg_err_o, 0);
    repeat (17000) @(negedge clk_i);

    cur_req = "R9";
    wr({fld(3,3,1,0,0), fld(0,0,0,1,1), fld(1,2,1,1,1), fld(2,2,1,1,1)});
    chk(cfg_err_o == 4'b0011, "R9 illegal flags", cfg_err_o, 3);
    repeat (17000) @(negedge clk_i);
    wr({fld(3,3,0,0,0), fld(0,0,0,0,0), fld(1,0,1,1,0), fld(2,1,0,0,1)});
    chk(cfg_err_o == 4'h0, "R9 cleared by legal write", cfg_err_o, 0);
    repeat (2000) @(negedge clk_i);

    live = 0;
    finish_run();
  end
endmodule